// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits in the write path of a byte-alterable EEPROM. It watches each host write cycle (an address and a data byte, marked by a one-cycle strobe) and decides whether the write may go on to the page-load logic. It also keeps a write-protect flag that is treated as nonvolatile. Changing that flag is not instant. The block raises a one-cycle request to program the flag, and the new value takes effect a fixed number of cycles later, standing in for the programming time of the cell.

Out of reset the flag is clear and every write is let through. A fixed three-write command arms protection. Once protection is armed, only writes that come right after that same three-write command are let through. The command opens a page window that accepts up to a set number of bytes. The window closes again when the page-load logic reports that the page has been handed over for programming, or when the byte limit is reached. A separate six-write command clears the flag. Any write that breaks a command sequence sends the sequencer back to its idle step. While protection is armed, such a write is also dropped. Command addresses and data values are parameters.

Top module: `wp_cmd_sequencer`

## Requirements
- R1: After reset, protection is off, `wr_permit` and `nv_req` are low, and the first write is permitted.
- R2: While protection is off, every write strobe produces `wr_permit` high in the following cycle only. `wr_permit` is never high without a write in the cycle before.
- R3: While protection is off, the writes (CMD_A,UNLOCK1), (CMD_B,UNLOCK2), (CMD_A,ARM_CODE) in a row raise `nv_req` for exactly one cycle with `nv_val`=1, in the cycle after the third write. Defaults: CMD_A=0x5555, CMD_B=0x2AAA, UNLOCK1=0xAA, UNLOCK2=0x55, ARM_CODE=0xA0.
- R4: A requested flag change takes effect at the TWC_CYCLES-th clock edge after the write that completed the command. Writes sampled before that edge still see the old protection state.
- R5: While protection is on and no page window is open, every write, including command writes, gives `wr_permit` low.
- R6: While protection is on, the three-write arm command opens a page window without raising `nv_req`. The writes that follow are permitted.
- R7: A `page_done` pulse closes the window, and later writes are refused again.
- R8: A window accepts at most PAGE_BYTES writes (default 128). The next write is refused.
- R9: While protection is on, the six writes (CMD_A,UNLOCK1), (CMD_B,UNLOCK2), (CMD_A,CLEAR_PRE), (CMD_A,UNLOCK1), (CMD_B,UNLOCK2), (CMD_A,CLEAR_CODE) raise `nv_req` with `nv_val`=0 after the sixth write. Writes stay refused until the change takes effect (R4). Defaults: CLEAR_PRE=0x80, CLEAR_CODE=0x20.
- R10: A write that does not match the next expected step returns the sequencer to idle, so a later final step alone has no effect.
- R11: Writes made while `prog_busy` is high, or while a flag change is pending, neither advance nor reset the sequencer and never raise `nv_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe marking a host write |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Data byte of the write |
| prog_busy | input | 1 | An internal programming cycle is running |
| page_done | input | 1 | Page-load logic has handed the page to programming |
| wr_permit | output | 1 | The write of the previous cycle may be loaded |
| nv_req | output | 1 | One-cycle request to program the protect flag |
| nv_val | output | 1 | Value to program, valid with `nv_req` |

## Verification
The assertions assume that `wr_valid` is a single-cycle strobe, that `page_done` is only pulsed between writes, and that `prog_busy` changes only between write strobes. The stimulus drives each write for exactly one cycle from the falling edge and pulses `page_done` on a cycle with no write. It holds `prog_busy` around a single write only. Every wait on a flag change keeps a margin of ten cycles either side of the commit edge, so no check depends on the exact cycle of a race.

// File: rtl/wp_seq_pkg.sv
// Package: shared step encoding for the protection command sequencer.
// Assumes: none; holds types only.
package wp_seq_pkg;

    // Position inside the arm or clear command stream
    typedef enum logic [2:0] {
        STEP_IDLE = 3'd0,  // waiting for first unlock write
        STEP_U1   = 3'd1,  // first unlock seen
        STEP_U2   = 3'd2,  // second unlock seen; arm or clear-prefix next
        STEP_C3   = 3'd3,  // clear prefix seen
        STEP_C4   = 3'd4,  // repeated first unlock seen
        STEP_C5   = 3'd5   // repeated second unlock seen
    } step_t;

endpackage

// File: rtl/wp_cmd_matcher.sv
// Module: tracks the command stream and flags a completed arm or clear command.
// Assumes: 'step_en' is high only for writes that the sequencer may consume;
// hit outputs are combinational and valid in the cycle of the completing write.
module wp_cmd_matcher
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CMD_A = 16'h5555,
    parameter logic [ADDR_W-1:0] CMD_B = 16'h2AAA,
    parameter logic [DATA_W-1:0] UNLOCK1 = 8'hAA,
    parameter logic [DATA_W-1:0] UNLOCK2 = 8'h55,
    parameter logic [DATA_W-1:0] ARM_CODE = 8'hA0,
    parameter logic [DATA_W-1:0] CLEAR_PRE = 8'h80,
    parameter logic [DATA_W-1:0] CLEAR_CODE = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              arm_hit,
    output logic              clear_hit
);

    step_t step_q, step_d;

    // Compare the current write with one expected address/data pair
    function automatic logic is_pair(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                                     input logic [ADDR_W-1:0] ea, input logic [DATA_W-1:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    // Next-step decode; any mismatch falls back to idle
    always_comb begin
        step_d    = step_q;
        arm_hit   = 1'b0;
        clear_hit = 1'b0;
        if (step_en) begin
            step_d = STEP_IDLE;
            unique case (step_q)
                STEP_IDLE: if (is_pair(addr, data, CMD_A, UNLOCK1)) step_d = STEP_U1;
                STEP_U1:   if (is_pair(addr, data, CMD_B, UNLOCK2)) step_d = STEP_U2;
                STEP_U2: begin
                    if (is_pair(addr, data, CMD_A, ARM_CODE))       arm_hit = 1'b1;
                    else if (is_pair(addr, data, CMD_A, CLEAR_PRE)) step_d  = STEP_C3;
                end
                STEP_C3:   if (is_pair(addr, data, CMD_A, UNLOCK1)) step_d = STEP_C4;
                STEP_C4:   if (is_pair(addr, data, CMD_B, UNLOCK2)) step_d = STEP_C5;
                STEP_C5:   if (is_pair(addr, data, CMD_A, CLEAR_CODE)) clear_hit = 1'b1;
                default:   step_d = STEP_IDLE;
            endcase
        end
    end

    // Step register
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= STEP_IDLE;
        else        step_q <= step_d;
    end

endmodule

// File: rtl/wp_nv_flag.sv
// Module: protect flag modelled as a nonvolatile bit with a fixed programming time.
// Assumes: 'start' is not raised while 'pending' is high; TWC_CYCLES >= 1.
module wp_nv_flag #(
    parameter int TWC_CYCLES = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_val,
    output logic prot,
    output logic pending
);

    localparam int TW = $clog2(TWC_CYCLES + 1);

    logic [TW-1:0] left_q;
    logic          val_q;

    // Programming timer: commit the new value once the count runs out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot    <= 1'b0;
            pending <= 1'b0;
            val_q   <= 1'b0;
            left_q  <= '0;
        end else if (start) begin
            pending <= 1'b1;
            val_q   <= start_val;
            left_q  <= TW'(TWC_CYCLES - 1);
        end else if (pending) begin
            if (left_q == '0) begin
                prot    <= val_q;
                pending <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/wp_page_window.sv
// Module: page window opened by an authorised command while protection is on.
// Assumes: 'open_req' and 'page_done' are never high together with a write
// that the window must count; PAGE_BYTES >= 1.
module wp_page_window #(
    parameter int PAGE_BYTES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic open_req,
    input  logic page_done,
    input  logic wr_in_win,
    output logic win_open,
    output logic [$clog2(PAGE_BYTES+1)-1:0] win_cnt
);

    localparam int CW = $clog2(PAGE_BYTES + 1);

    // Window state and byte count; closes on page hand-over or on the byte limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open <= 1'b0;
            win_cnt  <= '0;
        end else if (open_req) begin
            win_open <= 1'b1;
            win_cnt  <= '0;
        end else if (page_done) begin
            win_open <= 1'b0;
            win_cnt  <= '0;
        end else if (wr_in_win) begin
            if (win_cnt == CW'(PAGE_BYTES - 1)) begin
                win_open <= 1'b0;
                win_cnt  <= '0;
            end else begin
                win_cnt <= win_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wp_cmd_sequencer.sv
// Module: top of the write-protection sequencer. Gates host writes by the
// protect flag and the page window, and requests flag updates on commands.
// Assumes: wr_valid is a one-cycle strobe per host write; page_done is pulsed
// by the page-load logic when the page leaves for programming.
module wp_cmd_sequencer #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int TWC_CYCLES = 500,
    parameter int PAGE_BYTES = 128,
    parameter logic [ADDR_W-1:0] CMD_A = 16'h5555,
    parameter logic [ADDR_W-1:0] CMD_B = 16'h2AAA,
    parameter logic [DATA_W-1:0] UNLOCK1 = 8'hAA,
    parameter logic [DATA_W-1:0] UNLOCK2 = 8'h55,
    parameter logic [DATA_W-1:0] ARM_CODE = 8'hA0,
    parameter logic [DATA_W-1:0] CLEAR_PRE = 8'h80,
    parameter logic [DATA_W-1:0] CLEAR_CODE = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              prog_busy,
    input  logic              page_done,
    output logic              wr_permit,
    output logic              nv_req,
    output logic              nv_val
);

    localparam int CW = $clog2(PAGE_BYTES + 1);

    logic          prot_q, nv_pend;
    logic          win_open;
    logic [CW-1:0] win_cnt;
    logic          step_en, arm_hit, clear_hit;
    logic          upd_start, upd_val, open_req, allow;

    // Sequencer consumes writes only when idle from programming and outside a window
    assign step_en   = wr_valid && !prog_busy && !nv_pend && !win_open;
    assign upd_start = (arm_hit && !prot_q) || (clear_hit && prot_q);
    assign upd_val   = arm_hit;
    assign open_req  = arm_hit && prot_q;
    assign allow     = !prot_q || win_open;

    wp_cmd_matcher #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_A(CMD_A), .CMD_B(CMD_B),
        .UNLOCK1(UNLOCK1), .UNLOCK2(UNLOCK2), .ARM_CODE(ARM_CODE),
        .CLEAR_PRE(CLEAR_PRE), .CLEAR_CODE(CLEAR_CODE)
    ) u_match (
        .clk(clk), .rst_n(rst_n), .step_en(step_en),
        .addr(wr_addr), .data(wr_data),
        .arm_hit(arm_hit), .clear_hit(clear_hit)
    );

    wp_nv_flag #(.TWC_CYCLES(TWC_CYCLES)) u_flag (
        .clk(clk), .rst_n(rst_n), .start(upd_start), .start_val(upd_val),
        .prot(prot_q), .pending(nv_pend)
    );

    wp_page_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
        .clk(clk), .rst_n(rst_n), .open_req(open_req), .page_done(page_done),
        .wr_in_win(wr_valid && win_open),
        .win_open(win_open), .win_cnt(win_cnt)
    );

    // Output register: write verdict and flag-update request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_permit <= 1'b0;
            nv_req    <= 1'b0;
            nv_val    <= 1'b0;
        end else begin
            wr_permit <= wr_valid && allow;
            nv_req    <= upd_start;
            nv_val    <= upd_start ? upd_val : nv_val;
        end
    end

endmodule

// File: rtl/wp_seq_checker.sv
// Checker: temporal properties of the sequencer, bound to the top module.
// Assumes: wr_valid is a one-cycle strobe.
module wp_seq_checker #(
    parameter int PAGE_BYTES = 128
) (
    input logic clk,
    input logic rst_n,
    input logic wr_valid,
    input logic prog_busy,
    input logic wr_permit,
    input logic nv_req,
    input logic prot,
    input logic pend,
    input logic win_open,
    input logic [$clog2(PAGE_BYTES+1)-1:0] win_cnt
);

    // R2: a permit always answers a write of the cycle before
    assert_permit_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_permit |-> $past(wr_valid));

    // R3: the update request lasts one cycle
    assert_req_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |=> !nv_req);

    // R11: a request only follows a non-busy write made while no change was pending
    assert_req_needs_idle_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req |-> ($past(wr_valid) && !$past(prog_busy) && !$past(pend)));

    // R5: protected and no window means the write is refused
    assert_refuse_when_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && prot && !win_open) |=> !wr_permit);

    // R8: the window never holds more than the page size
    assert_window_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt < PAGE_BYTES);

    // R6: a window only exists while protection is on
    assert_window_only_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_open |-> prot);

endmodule

bind wp_cmd_sequencer wp_seq_checker #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .prog_busy(prog_busy),
    .wr_permit(wr_permit), .nv_req(nv_req), .prot(prot_q), .pend(nv_pend),
    .win_open(win_open), .win_cnt(win_cnt)
);

// File: tb/wp_cmd_sequencer_bench.sv
// Bench: scoreboard. The driver queues the expected verdict of every write,
// and the monitor pops and compares after the edge that samples that write.
module wp_cmd_sequencer_bench;

    localparam int TWC = 500;
    localparam int PAGE = 128;

    typedef struct {
        bit    permit;
        bit    req;
        bit    val;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        prog_busy = 1'b0;
    logic        page_done = 1'b0;
    logic        wr_permit, nv_req, nv_val;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    wp_cmd_sequencer #(.TWC_CYCLES(TWC), .PAGE_BYTES(PAGE)) u_wp_cmd_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .prog_busy(prog_busy), .page_done(page_done),
        .wr_permit(wr_permit), .nv_req(nv_req), .nv_val(nv_val)
    );

    // Driver: one write strobe, expected outcome pushed to the scoreboard
    task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit p,
                      input bit rq, input bit v, input string tag);
        exp_t e;
        e.permit = p; e.req = rq; e.val = v; e.tag = tag;
        sb.push_back(e);
        wr_addr = a; wr_data = d; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done();
        page_done = 1'b1;
        @(negedge clk);
        page_done = 1'b0;
    endtask

    task automatic arm_cmd(input bit p, input bit rq, input string tag);
        wr(16'h5555, 8'hAA, p, 1'b0, 1'b0, tag);
        wr(16'h2AAA, 8'h55, p, 1'b0, 1'b0, tag);
        wr(16'h5555, 8'hA0, p, rq, 1'b1, tag);
    endtask

    // Monitor: compare results one step after the edge that sampled a write
    initial begin
        forever begin
            @(posedge clk);
            begin
                bit   sampled;
                exp_t e;
                sampled = wr_valid;
                #2;
                if (sampled) begin
                    e = sb.pop_front();
                    checks++;
                    if (wr_permit !== e.permit || nv_req !== e.req || (e.req && nv_val !== e.val)) begin
                        fails++;
                        $display("FAIL %s: permit/req/val got %b/%b/%b expected %b/%b/%b",
                                 e.tag, wr_permit, nv_req, nv_val, e.permit, e.req, e.val);
                    end
                end else if (rst_n && nv_req !== 1'b0) begin
                    checks++;
                    fails++;
                    $display("FAIL R3: nv_req got %b expected 0 without a write", nv_req);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run incomplete, got timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        checks++;
        if (wr_permit !== 1'b0 || nv_req !== 1'b0) begin
            fails++;
            $display("FAIL R1: permit/req got %b/%b expected 0/0", wr_permit, nv_req);
        end
        wr(16'h0040, 8'h11, 1'b1, 1'b0, 1'b0, "R1 first write");
        // R2: open writes under several patterns
        wr(16'hFFFF, 8'h00, 1'b1, 1'b0, 1'b0, "R2");
        wr(16'h5555, 8'h20, 1'b1, 1'b0, 1'b0, "R2");
        wr(16'h1234, 8'hFF, 1'b1, 1'b0, 1'b0, "R2");
        idle(2);
        // R3: arm from unprotected; R4: old state holds until the commit edge
        arm_cmd(1'b1, 1'b1, "R3 arm");
        idle(TWC - 12);
        wr(16'h0300, 8'h3C, 1'b1, 1'b0, 1'b0, "R4 before commit");
        idle(20);
        wr(16'h0300, 8'h3C, 1'b0, 1'b0, 1'b0, "R4 after commit");
        // R5: plain and command writes refused; a mismatch resets the step
        wr(16'h1234, 8'h77, 1'b0, 1'b0, 1'b0, "R5 data");
        wr(16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, "R5 command");
        wr(16'h0100, 8'h01, 1'b0, 1'b0, 1'b0, "R5 data");
        // R6: authorised page; R7: page_done re-arms
        arm_cmd(1'b0, 1'b0, "R6 arm");
        wr(16'h0480, 8'hA1, 1'b1, 1'b0, 1'b0, "R6");
        wr(16'h0481, 8'hA2, 1'b1, 1'b0, 1'b0, "R6");
        wr(16'h0482, 8'hA3, 1'b1, 1'b0, 1'b0, "R6");
        pulse_done();
        wr(16'h0483, 8'hA4, 1'b0, 1'b0, 1'b0, "R7 after page_done");
        // R8: byte limit of the window
        arm_cmd(1'b0, 1'b0, "R8 arm");
        for (int i = 0; i < PAGE; i++)
            wr(16'h0600 + 16'(i), 8'(i), 1'b1, 1'b0, 1'b0, "R8 in page");
        wr(16'h0680, 8'h5A, 1'b0, 1'b0, 1'b0, "R8 over limit");
        // R10: mismatch drops to idle, lone final step does nothing
        wr(16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, "R10");
        wr(16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, "R10");
        wr(16'h5555, 8'h11, 1'b0, 1'b0, 1'b0, "R10 mismatch");
        wr(16'h5555, 8'hA0, 1'b0, 1'b0, 1'b0, "R10 lone final");
        wr(16'h0700, 8'h07, 1'b0, 1'b0, 1'b0, "R10 still locked");
        // R11: a busy write neither advances nor resets the command
        wr(16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, "R11");
        prog_busy = 1'b1;
        wr(16'h0000, 8'h99, 1'b0, 1'b0, 1'b0, "R11 busy");
        prog_busy = 1'b0;
        wr(16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, "R11");
        wr(16'h5555, 8'hA0, 1'b0, 1'b0, 1'b0, "R11");
        wr(16'h0800, 8'h08, 1'b1, 1'b0, 1'b0, "R11 window open");
        pulse_done();
        // R9: clear command, refused until commit, open after
        wr(16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, "R9");
        wr(16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, "R9");
        wr(16'h5555, 8'h80, 1'b0, 1'b0, 1'b0, "R9");
        wr(16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, "R9");
        wr(16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, "R9");
        wr(16'h5555, 8'h20, 1'b0, 1'b1, 1'b0, "R9 clear");
        idle(10);
        // R11: writes while the change is pending leave the sequencer alone
        arm_cmd(1'b0, 1'b0, "R11 pending");
        wr(16'h0900, 8'h09, 1'b0, 1'b0, 1'b0, "R9 still locked");
        idle(TWC);
        wr(16'h0901, 8'h0A, 1'b1, 1'b0, 1'b0, "R9 unlocked");
        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule